// File: doc/BRIEF.md
# Shared Receive Queue for a Four-Line Serial Multiplexer

This block collects received characters from several serial lines into one common queue. The rest of the chip reads that queue through a single 16-bit word. Each line's deserialiser presents a character with its framing and parity flags for one cycle. If that line's receiver is switched on, the character is trimmed to the line's configured width, tagged with the line number and stored. Software reads one word at a time and uses the tag in each word to route the character to the right line. It keeps reading until a word arrives with the valid bit clear.

Each line has a small configuration word that sets its character width and switches its receiver on or off. The low bits of the written word choose which line is updated. A receive-done status shows that the queue holds data. A receive interrupt is raised only while that status is set and the interrupt enable bit is also set. No separate break flag exists: a break shows up as a zero character that has the framing error bit set.

Top module: `rxq_mux_rx`

## Requirements
- R1: A valid read word carries bit 15 = 1. The character is in bits 7:0 and the source line number is in bits 11:8. With four lines, bits 11:10 are zero.
- R2: Bit 12 is the parity error, bit 13 the framing error and bit 14 the overrun. Each is set independently for the character it belongs to. A break appears as character 0 with bit 13 set.
- R3: While the queue is empty, the read word is all zeros. A read strobe on an empty queue changes nothing. Each read strobe on a non-empty queue removes exactly one entry, and entries leave in arrival order.
- R4: `rx_done` is high exactly while the queue holds an entry. `rx_irq` is high only while `rx_done` and the interrupt enable are both high. The interrupt enable is loaded from `ctl_rie` when `ctl_we` is high and is 0 after reset.
- R5: When several lines deliver a character in the same cycle, they are stored in order of increasing line number.
- R6: The queue holds 16 entries. A character that arrives while the queue is full is dropped. The next character that is stored after a drop has bit 14 set, and only that one.
- R7: Characters on a line whose receiver is disabled are discarded. After reset, every receiver is disabled.
- R8: A write on `lp_wdata` uses three fields. Bits 3:0 select the line. Bits 9:8 set the width code, where 0..3 mean 5..8 bits. Bit 12 enables the receiver. Stored characters keep only the low bits of the configured width. Reset sets the width to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 4 | Per-line character strobe, one cycle |
| rx_data | input | 32 | Per-line character, line i at bits 8i+7:8i |
| rx_ferr | input | 4 | Per-line framing error flag |
| rx_perr | input | 4 | Per-line parity error flag |
| lp_we | input | 1 | Line parameter write strobe |
| lp_wdata | input | 16 | Line parameter word (R8 layout) |
| ctl_we | input | 1 | Control write strobe |
| ctl_rie | input | 1 | Receive interrupt enable value |
| rd_en | input | 1 | Read strobe; pops one entry |
| rd_data | output | 16 | Receive word at the queue head |
| rx_done | output | 1 | Queue holds at least one entry |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Some properties are checked on every cycle: the interrupt never rises without data, the word is zero while the queue is empty, and valid words carry a legal line tag. The occupancy never passes the depth, a lone read removes exactly one entry, and the head word holds still when nothing happens. Other behaviours need the bench's scenarios: lowest-line-first ordering when arrivals coincide, overrun marking on exactly one entry after a drop, width trimming, break encoding, and discarding on disabled receivers. Each of these depends on sequences of stimulus and specific data values.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W     = 8;
    localparam int LINE_FLD_W = 4;
    localparam int WORD_W     = 16;
    localparam int SZ_LSB     = 8;
    localparam int EN_BIT     = 12;

    typedef struct packed {
        logic                  ovr;
        logic                  ferr;
        logic                  perr;
        logic [LINE_FLD_W-1:0] line;
        logic [CHAR_W-1:0]     ch;
    } rx_ent_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic vld, input rx_ent_t e);
        return vld ? {1'b1, e} : '0;
    endfunction

    function automatic logic [CHAR_W-1:0] width_mask(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction
endpackage

// File: rtl/rxq_line_cfg.sv
module rxq_line_cfg #(
    parameter int NUM_LINES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   lp_we,
    input  logic [15:0]            lp_wdata,
    output logic [NUM_LINES-1:0]   line_en,
    output logic [2*NUM_LINES-1:0] line_sz
);
    import rxq_pkg::*;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic hit;
        assign hit = lp_we && (lp_wdata[3:0] == 4'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                line_en[i]       <= 1'b0;
                line_sz[2*i +: 2] <= 2'd3;
            end else if (hit) begin
                line_en[i]       <= lp_wdata[EN_BIT];
                line_sz[2*i +: 2] <= lp_wdata[SZ_LSB +: 2];
            end
        end
    end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int N     = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     wr_vld,
    input  rxq_pkg::rx_ent_t wr_ent [N],
    input  logic             pop,
    output rxq_pkg::rx_ent_t head,
    output logic             empty,
    output logic [CNT_W-1:0] occ,
    output logic [N-1:0]     stored,
    output logic             drop
);
    import rxq_pkg::*;

    rx_ent_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] space, n_acc;
    logic [PTR_W-1:0] waddr [N];
    logic             pop_ok;

    assign space  = CNT_W'(DEPTH) - occ;
    assign empty  = (occ == '0);
    assign pop_ok = pop && !empty;
    assign head   = mem[rd_ptr];

    always_comb begin
        logic [CNT_W-1:0] rank;
        rank   = '0;
        stored = '0;
        for (int i = 0; i < N; i++) begin
            waddr[i] = wr_ptr + rank[PTR_W-1:0];
            if (wr_vld[i]) begin
                stored[i] = (rank < space);
                rank      = rank + 1'b1;
            end
        end
        n_acc = '0;
        for (int i = 0; i < N; i++) n_acc = n_acc + CNT_W'(stored[i]);
        drop = |(wr_vld & ~stored);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++)
            if (stored[i]) mem[waddr[i]] <= wr_ent[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            wr_ptr <= wr_ptr + n_acc[PTR_W-1:0];
            rd_ptr <= rd_ptr + PTR_W'(pop_ok);
            occ    <= occ + n_acc - CNT_W'(pop_ok);
        end
    end
endmodule

// File: rtl/rxq_mux_rx.sv
module rxq_mux_rx #(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_LINES-1:0]   rx_valid,
    input  logic [8*NUM_LINES-1:0] rx_data,
    input  logic [NUM_LINES-1:0]   rx_ferr,
    input  logic [NUM_LINES-1:0]   rx_perr,
    input  logic                   lp_we,
    input  logic [15:0]            lp_wdata,
    input  logic                   ctl_we,
    input  logic                   ctl_rie,
    input  logic                   rd_en,
    output logic [15:0]            rd_data,
    output logic                   rx_done,
    output logic                   rx_irq
);
    import rxq_pkg::*;

    logic [NUM_LINES-1:0]   line_en;
    logic [2*NUM_LINES-1:0] line_sz;
    logic [NUM_LINES-1:0]   gv, stored;
    rx_ent_t                ent [NUM_LINES];
    rx_ent_t                head;
    logic                   empty, drop, ovr_pend, rie;
    logic [CNT_W-1:0]       occ;

    rxq_line_cfg #(.NUM_LINES(NUM_LINES)) u_cfg (
        .clk(clk), .rst(rst), .lp_we(lp_we), .lp_wdata(lp_wdata),
        .line_en(line_en), .line_sz(line_sz)
    );

    assign gv = rx_valid & line_en;

    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            ent[i].ch   = rx_data[8*i +: 8] & width_mask(line_sz[2*i +: 2]);
            ent[i].line = LINE_FLD_W'(i);
            ent[i].ferr = rx_ferr[i];
            ent[i].perr = rx_perr[i];
            ent[i].ovr  = ovr_pend && !seen;
            seen        = seen | gv[i];
        end
    end

    rxq_fifo #(.DEPTH(DEPTH), .N(NUM_LINES)) u_fifo (
        .clk(clk), .rst(rst), .wr_vld(gv), .wr_ent(ent), .pop(rd_en),
        .head(head), .empty(empty), .occ(occ), .stored(stored), .drop(drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_pend <= 1'b0;
            rie      <= 1'b0;
        end else begin
            ovr_pend <= drop || (ovr_pend && !(|stored));
            if (ctl_we) rie <= ctl_rie;
        end
    end

    assign rd_data = pack_word(!empty, head);
    assign rx_done = !empty;
    assign rx_irq  = rie && !empty;
endmodule

// File: rtl/rxq_mux_rx_chk.sv
module rxq_mux_rx_chk #(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] rx_valid,
    input logic                 rd_en,
    input logic [15:0]          rd_data,
    input logic                 rx_done,
    input logic                 rx_irq,
    input logic [CNT_W-1:0]     occ
);
    p_irq_needs_data_r4: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_done);

    p_empty_word_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> rd_data == 16'h0000);

    p_word_tag_r1: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (rd_data[15] && (32'(rd_data[11:8]) < NUM_LINES)));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        32'(occ) <= DEPTH);

    p_pop_one_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rx_done && rx_valid == '0) |=> occ == $past(occ) - 1'b1);

    p_head_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && rx_valid == '0) |=> $stable(rd_data));
endmodule

bind rxq_mux_rx rxq_mux_rx_chk #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rd_en(rd_en),
    .rd_data(rd_data), .rx_done(rx_done), .rx_irq(rx_irq), .occ(occ)
);

// File: tb/rxq_mux_rx_test.sv
module rxq_mux_rx_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rx_valid, rx_ferr, rx_perr;
    logic [31:0] rx_data;
    logic        lp_we, ctl_we, ctl_rie, rd_en;
    logic [15:0] lp_wdata, rd_data;
    logic        rx_done, rx_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rxq_mux_rx uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ferr(rx_ferr), .rx_perr(rx_perr), .lp_we(lp_we), .lp_wdata(lp_wdata),
        .ctl_we(ctl_we), .ctl_rie(ctl_rie), .rd_en(rd_en), .rd_data(rd_data),
        .rx_done(rx_done), .rx_irq(rx_irq)
    );

    // fields: [31:28] line, [27:20] char, [17] ferr, [16] perr, [15:0] expected word
    localparam logic [31:0] VEC [0:5] = '{
        32'h1_41_0_8141,
        32'h2_7E_1_927E,
        32'h0_00_2_A000,
        32'h3_C3_3_B3C3,
        32'h0_FF_0_80FF,
        32'h2_5A_2_A25A
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input int line, input int code, input bit en);
        @(negedge clk);
        lp_wdata = 16'((32'(en) << 12) | (code << 8) | line);
        lp_we    = 1'b1;
        @(negedge clk);
        lp_we    = 1'b0;
    endtask

    task automatic arrive(input int line, input logic [7:0] d, input bit fe, input bit pe);
        @(negedge clk);
        rx_valid       = '0;
        rx_valid[line] = 1'b1;
        rx_data[8*line +: 8] = d;
        rx_ferr[line]  = fe;
        rx_perr[line]  = pe;
        @(negedge clk);
        rx_valid = '0;
        rx_ferr  = '0;
        rx_perr  = '0;
    endtask

    task automatic read_word(output logic [15:0] w);
        @(negedge clk);
        w     = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] w;
        rst = 1'b1; rx_valid = '0; rx_ferr = '0; rx_perr = '0; rx_data = '0;
        lp_we = 1'b0; lp_wdata = '0; ctl_we = 1'b0; ctl_rie = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R3 reset word", rd_data, 16'h0000);
        check("R4 reset done/irq", {14'd0, rx_done, rx_irq}, 16'h0000);

        // R7: receivers disabled after reset
        arrive(0, 8'h33, 0, 0);
        check("R7 disabled after reset", {15'd0, rx_done}, 16'h0000);

        for (int l = 0; l < 4; l++) cfg(l, 3, 1);

        // R1 R2: table walk
        for (int k = 0; k < 6; k++) begin
            arrive(int'(VEC[k][31:28]), VEC[k][27:20], VEC[k][17], VEC[k][16]);
            read_word(w);
            check("R1 R2 table word", w, VEC[k][15:0]);
        end

        // R3: empty read returns zero and leaves nothing behind
        read_word(w);
        check("R3 empty read", w, 16'h0000);
        check("R3 still empty", {15'd0, rx_done}, 16'h0000);

        // R5: simultaneous arrival, lowest line first
        @(negedge clk);
        rx_valid = 4'hF;
        rx_data  = 32'hA3A2A1A0;
        @(negedge clk);
        rx_valid = '0;
        for (int l = 0; l < 4; l++) begin
            read_word(w);
            check("R5 order", w, 16'h8000 | 16'(l << 8) | 16'(8'hA0 + l));
        end

        // R7: disabled line discards, others keep working
        cfg(2, 3, 0);
        arrive(2, 8'h77, 0, 0);
        check("R7 disabled line", {15'd0, rx_done}, 16'h0000);
        arrive(1, 8'h12, 0, 0);
        read_word(w);
        check("R7 other line", w, 16'h8112);
        cfg(2, 3, 1);

        // R8: width trimming; R2 break encoding
        cfg(3, 0, 1);
        arrive(3, 8'hFF, 0, 0);
        read_word(w);
        check("R8 5-bit", w, 16'h831F);
        cfg(3, 1, 1);
        arrive(3, 8'hFF, 0, 0);
        read_word(w);
        check("R8 6-bit", w, 16'h833F);
        cfg(3, 0, 1);
        arrive(3, 8'hE0, 1, 0);
        read_word(w);
        check("R2 break", w, 16'hA300);
        cfg(3, 3, 1);

        // R4: interrupt gating
        arrive(0, 8'h5C, 0, 0);
        check("R4 done no enable", {14'd0, rx_done, rx_irq}, 16'h0002);
        @(negedge clk); ctl_we = 1'b1; ctl_rie = 1'b1;
        @(negedge clk); ctl_we = 1'b0;
        check("R4 irq enabled", {14'd0, rx_done, rx_irq}, 16'h0003);
        read_word(w);
        check("R4 irq after drain", {14'd0, rx_done, rx_irq}, 16'h0000);
        @(negedge clk); ctl_we = 1'b1; ctl_rie = 1'b0;
        @(negedge clk); ctl_we = 1'b0;

        // R6: fill, overflow, overrun marking
        for (int k = 0; k < 16; k++) arrive(0, 8'(k), 0, 0);
        arrive(0, 8'hEE, 0, 0);
        for (int k = 0; k < 16; k++) begin
            read_word(w);
            check("R6 stored entry", w, 16'h8000 | 16'(k));
        end
        read_word(w);
        check("R6 dropped char absent", w, 16'h0000);
        arrive(1, 8'h55, 0, 0);
        read_word(w);
        check("R6 overrun marked", w, 16'hC155);
        arrive(1, 8'h66, 0, 0);
        read_word(w);
        check("R6 overrun once", w, 16'h8166);

        finish_run();
    end
endmodule